// File: doc/BRIEF.md
# Load-String Word Sequencer

This block sequences a multi-register string load for a 64-bit big-endian integer core. When started, it works out the byte count and the effective address, then fetches bytes one at a time over a simple request/response memory port. It packs the bytes into 32-bit words and writes each word to the register file, stepping the destination index through consecutive registers.

Two forms are supported. In the immediate form, the count comes from a small instruction field. In the indexed form, the count comes from the low bits of the fixed-point exception register, and the address is the sum of two register values. The sequencer stops early rather than overwrite a register that supplied the address. In little-endian mode it raises an alignment fault and touches nothing.

Top module: `strload_top`

## Requirements
- R1: Memory bytes fill each 32-bit word starting at the most significant byte. Consecutive bytes 01,02,03,04 produce the word 0x01020304.
- R2: A word that receives fewer than 4 bytes has its unfilled low bytes cleared to zero. Three bytes 01,02,03 give 0x01020300.
- R3: Every register write carries the word in bits 31:0 and zero in bits 63:32.
- R4: In the immediate form, a count field of 0 means 32 bytes (8 registers). In general ceil(count/4) registers are written, and the register after the last one keeps its old value.
- R5: In the indexed form, the count is taken from `xerCount`. The address is `baseB` plus `baseA`, where `baseA` is replaced by 0 when `raIdx` is 0. In the immediate form the address is `baseA`, or 0 when `raIdx` is 0.
- R6: The destination index increments modulo 32, so register 31 is followed by register 0.
- R7: If the next destination equals a nonzero `raIdx`, or equals `rbIdx` in the indexed form, the operation ends before that register and the register is not written.
- R8: With `littleEndian` high, a start produces exactly one cycle of `alignFault`, one cycle after start. It produces no memory request, no register write, no `busy` and no `done`.
- R9: An indexed-form start with a count of 0 issues no memory request, writes no register and pulses `done`.
- R10: `busy` rises the cycle after an accepted start and stays high through the single-cycle `done` pulse. `memReq` is only raised while `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| isIndexed | input | 1 | 1 = indexed form, 0 = immediate form |
| littleEndian | input | 1 | Core is in little-endian mode |
| immCount | input | 5 | Immediate byte count (0 means 32) |
| xerCount | input | 7 | Indexed-form byte count |
| rtIdx | input | 5 | First destination register index |
| raIdx | input | 5 | Address-base register index (0 = none) |
| rbIdx | input | 5 | Index register (indexed form) |
| baseA | input | 64 | Value of the address-base register |
| baseB | input | 64 | Value of the index register |
| memReq | output | 1 | Byte read request |
| memAddr | output | 64 | Byte address of the request |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 8 | Read byte |
| rfWe | output | 1 | Register-file write enable |
| rfAddr | output | 5 | Register-file write index |
| rfData | output | 64 | Register-file write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| alignFault | output | 1 | One-cycle alignment-fault pulse |

## Verification
The bench uses the default parameters: 64-bit registers, 32-bit words, 32 registers and a 7-bit indexed count. These make the full 32-byte immediate case, the wrap from register 31 to 0, and protection on both base registers reachable with short directed operations. A one-cycle-latency memory model returns address+1 as data. A shadow register file preset to all ones shows which registers were written and which were left alone.

// File: rtl/strload_pkg.sv
package strload_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_DONE} seqState_t;

  typedef struct packed {
    logic loadStart;
    logic issue;
    logic capture;
    logic writeWord;
  } seqCmd_t;

  typedef struct packed {
    logic laneZero;
    logic laneLast;
    logic lastByte;
    logic countZero;
    logic protHit;
    logic startZero;
  } seqStat_t;
endpackage

// File: rtl/strload_dpath.sv
module strload_dpath
  import strload_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int WORD_W    = 32,
  parameter int REG_IDX_W = 5,
  parameter int IMM_W     = 5,
  parameter int CNT_W     = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  seqCmd_t              cmd,
  input  logic                 isIndexed,
  input  logic [IMM_W-1:0]     immCount,
  input  logic [CNT_W-1:0]     xerCount,
  input  logic [REG_IDX_W-1:0] rtIdx,
  input  logic [REG_IDX_W-1:0] raIdx,
  input  logic [REG_IDX_W-1:0] rbIdx,
  input  logic [XLEN-1:0]      baseA,
  input  logic [XLEN-1:0]      baseB,
  input  logic [7:0]           memRspData,
  output seqStat_t             stat,
  output logic [XLEN-1:0]      memAddr,
  output logic [REG_IDX_W-1:0] rfAddr,
  output logic [XLEN-1:0]      rfData
);
  localparam int BYTES  = WORD_W / 8;
  localparam int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [CNT_W-1:0] IMM_FULL = CNT_W'(1 << IMM_W);

  logic [XLEN-1:0]      addrQ;
  logic [CNT_W-1:0]     remainQ;
  logic [REG_IDX_W-1:0] destQ, raQ, rbQ;
  logic                 idxQ;
  logic [LANE_W-1:0]    laneQ;
  logic [WORD_W-1:0]    wordQ;

  logic [XLEN-1:0]  raVal, effAddr;
  logic [CNT_W-1:0] effCount;

  always_comb begin
    raVal    = (raIdx == '0) ? '0 : baseA;
    effAddr  = isIndexed ? (raVal + baseB) : raVal;
    if (isIndexed)           effCount = xerCount;
    else if (immCount == '0) effCount = IMM_FULL;
    else                     effCount = CNT_W'(immCount);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ   <= '0;
      remainQ <= '0;
      destQ   <= '0;
      raQ     <= '0;
      rbQ     <= '0;
      idxQ    <= 1'b0;
      laneQ   <= '0;
      wordQ   <= '0;
    end else if (cmd.loadStart) begin
      addrQ   <= effAddr;
      remainQ <= effCount;
      destQ   <= rtIdx;
      raQ     <= raIdx;
      rbQ     <= rbIdx;
      idxQ    <= isIndexed;
      laneQ   <= '0;
      wordQ   <= '0;
    end else if (cmd.capture) begin
      for (int b = 0; b < BYTES; b++) begin
        if (laneQ == LANE_W'(b)) wordQ[WORD_W-1-8*b -: 8] <= memRspData;
      end
      laneQ   <= laneQ + 1'b1;
      addrQ   <= addrQ + 1'b1;
      remainQ <= remainQ - 1'b1;
    end else if (cmd.writeWord) begin
      destQ <= destQ + 1'b1;
      laneQ <= '0;
      wordQ <= '0;
    end
  end

  always_comb begin
    stat.laneZero  = (laneQ == '0);
    stat.laneLast  = (laneQ == LANE_W'(BYTES - 1));
    stat.lastByte  = (remainQ == CNT_W'(1));
    stat.countZero = (remainQ == '0);
    stat.protHit   = ((raQ != '0) && (destQ == raQ)) || (idxQ && (destQ == rbQ));
    stat.startZero = isIndexed && (xerCount == '0);
  end

  assign memAddr = addrQ;
  assign rfAddr  = destQ;
  assign rfData  = {{(XLEN-WORD_W){1'b0}}, wordQ};
endmodule

// File: rtl/strload_ctrl.sv
module strload_ctrl
  import strload_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     littleEndian,
  input  logic     memRspValid,
  input  seqStat_t stat,
  output seqCmd_t  cmd,
  output logic     busy,
  output logic     done,
  output logic     alignFault
);
  seqState_t state, stateNxt;
  logic pending, faultQ;

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start && !littleEndian) begin
          cmd.loadStart = 1'b1;
          stateNxt = stat.startZero ? ST_DONE : ST_READ;
        end
      end
      ST_READ: begin
        if (!pending) begin
          // stop before a word whose destination holds an address source
          if (stat.laneZero && stat.protHit) stateNxt = ST_DONE;
          else cmd.issue = 1'b1;
        end else if (memRspValid) begin
          cmd.capture = 1'b1;
          if (stat.lastByte || stat.laneLast) stateNxt = ST_WRITE;
        end
      end
      ST_WRITE: begin
        cmd.writeWord = 1'b1;
        stateNxt = stat.countZero ? ST_DONE : ST_READ;
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      faultQ  <= 1'b0;
    end else begin
      state  <= stateNxt;
      faultQ <= (state == ST_IDLE) && start && littleEndian;
      if (cmd.issue)        pending <= 1'b1;
      else if (cmd.capture) pending <= 1'b0;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);
  assign alignFault = faultQ;
endmodule

// File: rtl/strload_top.sv
module strload_top
  import strload_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int WORD_W    = 32,
  parameter int NREGS     = 32,
  parameter int IMM_W     = 5,
  parameter int CNT_W     = 7,
  localparam int REG_IDX_W = $clog2(NREGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 isIndexed,
  input  logic                 littleEndian,
  input  logic [IMM_W-1:0]     immCount,
  input  logic [CNT_W-1:0]     xerCount,
  input  logic [REG_IDX_W-1:0] rtIdx,
  input  logic [REG_IDX_W-1:0] raIdx,
  input  logic [REG_IDX_W-1:0] rbIdx,
  input  logic [XLEN-1:0]      baseA,
  input  logic [XLEN-1:0]      baseB,
  output logic                 memReq,
  output logic [XLEN-1:0]      memAddr,
  input  logic                 memRspValid,
  input  logic [7:0]           memRspData,
  output logic                 rfWe,
  output logic [REG_IDX_W-1:0] rfAddr,
  output logic [XLEN-1:0]      rfData,
  output logic                 busy,
  output logic                 done,
  output logic                 alignFault
);
  seqCmd_t  cmd;
  seqStat_t stat;

  strload_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .littleEndian(littleEndian),
    .memRspValid(memRspValid), .stat(stat), .cmd(cmd),
    .busy(busy), .done(done), .alignFault(alignFault)
  );

  strload_dpath #(
    .XLEN(XLEN), .WORD_W(WORD_W), .REG_IDX_W(REG_IDX_W), .IMM_W(IMM_W), .CNT_W(CNT_W)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .isIndexed(isIndexed),
    .immCount(immCount), .xerCount(xerCount), .rtIdx(rtIdx), .raIdx(raIdx),
    .rbIdx(rbIdx), .baseA(baseA), .baseB(baseB), .memRspData(memRspData),
    .stat(stat), .memAddr(memAddr), .rfAddr(rfAddr), .rfData(rfData)
  );

  assign memReq = cmd.issue;
  assign rfWe   = cmd.writeWord;
endmodule

// File: rtl/strload_chk.sv
module strload_chk #(
  parameter int XLEN      = 64,
  parameter int WORD_W    = 32,
  parameter int REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 isIndexed,
  input logic [REG_IDX_W-1:0] raIdx,
  input logic [REG_IDX_W-1:0] rbIdx,
  input logic                 memReq,
  input logic                 rfWe,
  input logic [REG_IDX_W-1:0] rfAddr,
  input logic [XLEN-1:0]      rfData,
  input logic                 busy,
  input logic                 done,
  input logic                 alignFault
);
  logic [REG_IDX_W-1:0] raL, rbL;
  logic idxL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raL <= '0; rbL <= '0; idxL <= 1'b0;
    end else if (start && !busy) begin
      raL <= raIdx; rbL <= rbIdx; idxL <= isIndexed;
    end
  end

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rfWe |-> (rfData[XLEN-1:WORD_W] == '0));

  p_no_protected_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rfWe |-> !(((raL != '0) && (rfAddr == raL)) || (idxL && (rfAddr == rbL))));

  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alignFault |-> (!busy && !memReq && !rfWe && !done));

  p_fault_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alignFault |=> !alignFault);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_req_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> busy);

  p_done_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

bind strload_top strload_chk #(
  .XLEN(XLEN), .WORD_W(WORD_W), .REG_IDX_W(REG_IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .isIndexed(isIndexed),
  .raIdx(raIdx), .rbIdx(rbIdx), .memReq(memReq), .rfWe(rfWe),
  .rfAddr(rfAddr), .rfData(rfData), .busy(busy), .done(done),
  .alignFault(alignFault)
);

// File: tb/tb_strload_top.sv
module tb_strload_top;
  localparam logic [63:0] ONES = '1;
  localparam logic [63:0] BASE = 64'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, isIndexed = 1'b0, littleEndian = 1'b0;
  logic [4:0] immCount = '0;
  logic [6:0] xerCount = '0;
  logic [4:0] rtIdx = '0, raIdx = '0, rbIdx = '0;
  logic [63:0] baseA = '0, baseB = '0;
  logic memReq, memRspValid;
  logic [63:0] memAddr;
  logic [7:0] memRspData;
  logic rfWe, busy, done, alignFault;
  logic [4:0] rfAddr;
  logic [63:0] rfData;

  int total = 0, bad = 0, cycles = 0;
  logic clrCnt = 1'b0, preset = 1'b0;
  int reqCnt, writeCnt, faultCnt, doneCnt;
  logic [63:0] rfModel [32];

  always #10 clk = ~clk;

  strload_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .isIndexed(isIndexed),
    .littleEndian(littleEndian), .immCount(immCount), .xerCount(xerCount),
    .rtIdx(rtIdx), .raIdx(raIdx), .rbIdx(rbIdx), .baseA(baseA), .baseB(baseB),
    .memReq(memReq), .memAddr(memAddr), .memRspValid(memRspValid),
    .memRspData(memRspData), .rfWe(rfWe), .rfAddr(rfAddr), .rfData(rfData),
    .busy(busy), .done(done), .alignFault(alignFault)
  );

  // memory model: one cycle latency, byte at offset k holds k+1
  always @(posedge clk) begin
    memRspValid <= memReq;
    memRspData  <= 8'(memAddr[6:0]) + 8'd1;
  end

  always @(posedge clk) begin
    if (preset) begin
      for (int i = 0; i < 32; i++) rfModel[i] <= ONES;
    end else if (rfWe) begin
      rfModel[rfAddr] <= rfData;
    end
    if (clrCnt) begin
      reqCnt <= 0; writeCnt <= 0; faultCnt <= 0; doneCnt <= 0;
    end else begin
      reqCnt   <= reqCnt + int'(memReq);
      writeCnt <= writeCnt + int'(rfWe);
      faultCnt <= faultCnt + int'(alignFault);
      doneCnt  <= doneCnt + int'(done);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic prep();
    @(negedge clk);
    preset = 1'b1; clrCnt = 1'b1;
    @(negedge clk);
    preset = 1'b0; clrCnt = 1'b0;
  endtask

  task automatic runOp(input bit idx, input bit le, input logic [4:0] imm, input logic [6:0] xer,
                       input logic [4:0] rt, input logic [4:0] ra, input logic [4:0] rb,
                       input logic [63:0] a, input logic [63:0] b);
    prep();
    isIndexed = idx; littleEndian = le; immCount = imm; xerCount = xer;
    rtIdx = rt; raIdx = ra; rbIdx = rb; baseA = a; baseB = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 400; n++) begin
      if (!busy) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic tReset();
    chkEq("R10 reset busy", 64'(busy), 64'd0);
    chkEq("R10 reset done", 64'(done), 64'd0);
    chkEq("R10 reset memReq", 64'(memReq), 64'd0);
    chkEq("R8 reset alignFault", 64'(alignFault), 64'd0);
  endtask

  task automatic tPartial();
    runOp(1'b0, 1'b0, 5'd3, 7'd0, 5'd11, 5'd3, 5'd0, BASE, 64'd0);
    chkEq("R2 partial word r11", rfModel[11], 64'h0000_0000_0102_0300);
    chkEq("R4 r12 untouched", rfModel[12], ONES);
    chkEq("R4 one write", 64'(writeCnt), 64'd1);
    chkEq("R10 one done", 64'(doneCnt), 64'd1);
  endtask

  task automatic tImmZero();
    runOp(1'b0, 1'b0, 5'd0, 7'd0, 5'd11, 5'd3, 5'd0, BASE, 64'd0);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      w = {8'(4*i+1), 8'(4*i+2), 8'(4*i+3), 8'(4*i+4)};
      chkEq("R1 R3 full word", rfModel[11+i], {32'd0, w});
    end
    chkEq("R4 r19 untouched", rfModel[19], ONES);
    chkEq("R4 32 reads", 64'(reqCnt), 64'd32);
  endtask

  task automatic tIndexed();
    // ra=5 nonzero: address = BASE + 4
    runOp(1'b1, 1'b0, 5'd0, 7'd8, 5'd20, 5'd5, 5'd6, BASE, 64'd4);
    chkEq("R5 indexed word 0", rfModel[20], 64'h0506_0708);
    chkEq("R5 indexed word 1", rfModel[21], 64'h090a_0b0c);
    chkEq("R5 r22 untouched", rfModel[22], ONES);
    // ra=0: base register replaced by zero, address = baseB
    runOp(1'b1, 1'b0, 5'd0, 7'd5, 5'd20, 5'd0, 5'd6, 64'hdead_0000, BASE + 64'd2);
    chkEq("R5 ra0 word 0", rfModel[20], 64'h0304_0506);
    chkEq("R5 ra0 word 1", rfModel[21], 64'h0700_0000);
  endtask

  task automatic tWrap();
    runOp(1'b0, 1'b0, 5'd8, 7'd0, 5'd31, 5'd3, 5'd0, BASE, 64'd0);
    chkEq("R6 r31", rfModel[31], 64'h0102_0304);
    chkEq("R6 wrap r0", rfModel[0], 64'h0506_0708);
    chkEq("R6 r1 untouched", rfModel[1], ONES);
  endtask

  task automatic tProtect();
    runOp(1'b0, 1'b0, 5'd10, 7'd0, 5'd31, 5'd1, 5'd0, BASE, 64'd0);
    chkEq("R7 imm r31", rfModel[31], 64'h0102_0304);
    chkEq("R7 imm r0", rfModel[0], 64'h0506_0708);
    chkEq("R7 ra r1 kept", rfModel[1], ONES);
    chkEq("R7 imm two writes", 64'(writeCnt), 64'd2);
    runOp(1'b1, 1'b0, 5'd0, 7'd12, 5'd31, 5'd0, 5'd0, 64'd0, BASE);
    chkEq("R7 idx r31", rfModel[31], 64'h0102_0304);
    chkEq("R7 rb r0 kept", rfModel[0], ONES);
    chkEq("R7 r1 untouched", rfModel[1], ONES);
    chkEq("R7 idx one write", 64'(writeCnt), 64'd1);
  endtask

  task automatic tFault();
    prep();
    isIndexed = 1'b0; littleEndian = 1'b1; immCount = 5'd4; rtIdx = 5'd11; raIdx = 5'd3; baseA = BASE;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chkEq("R8 fault pulse", 64'(alignFault), 64'd1);
    chkEq("R8 no busy", 64'(busy), 64'd0);
    @(negedge clk);
    chkEq("R8 fault drops", 64'(alignFault), 64'd0);
    repeat (3) @(negedge clk);
    chkEq("R8 single fault", 64'(faultCnt), 64'd1);
    chkEq("R8 no reads", 64'(reqCnt), 64'd0);
    chkEq("R8 no writes", 64'(writeCnt), 64'd0);
    chkEq("R8 no done", 64'(doneCnt), 64'd0);
    littleEndian = 1'b0;
  endtask

  task automatic tZeroCount();
    runOp(1'b1, 1'b0, 5'd0, 7'd0, 5'd11, 5'd0, 5'd2, 64'd0, BASE);
    chkEq("R9 zero count done", 64'(doneCnt), 64'd1);
    chkEq("R9 zero count reads", 64'(reqCnt), 64'd0);
    chkEq("R9 zero count writes", 64'(writeCnt), 64'd0);
    chkEq("R9 r11 untouched", rfModel[11], ONES);
  endtask

  task automatic tBusy();
    prep();
    isIndexed = 1'b0; littleEndian = 1'b0; immCount = 5'd2; rtIdx = 5'd4; raIdx = 5'd3; baseA = BASE;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chkEq("R10 busy after start", 64'(busy), 64'd1);
    for (int n = 0; n < 100; n++) begin
      if (done) break;
      chkEq("R10 busy held", 64'(busy), 64'd1);
      @(negedge clk);
    end
    chkEq("R10 done with busy", 64'(busy), 64'd1);
    @(negedge clk);
    chkEq("R10 done dropped", 64'(done), 64'd0);
    chkEq("R10 idle after done", 64'(busy), 64'd0);
    chkEq("R2 two bytes", rfModel[4], 64'h0102_0000);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      cycles = c;
    end
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=finish", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rst_n = 1'b1;
    @(negedge clk);
    tPartial();
    tImmZero();
    tIndexed();
    tWrap();
    tProtect();
    tFault();
    tZeroCount();
    tBusy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule